// File: doc/BRIEF.md
# Sample Acquisition Sequencer with Two-Limit Watchdog

This block carries out one instruction for a multiplexed sample-and-convert front end. On a start pulse it latches a 16-bit instruction word and two 16-bit limit words. It then drives the positive and negative input-mux channel selects and holds the track/hold stage in tracking for a number of clocks. That number depends on the resolution mode and on a 4-bit delay field in the instruction.

After tracking ends, the block raises a conversion request to an external converter and waits for the converter's done strobe. The strobe comes with a 13-bit two's-complement result.

In watchdog mode the block reduces the captured result to sign plus 8 bits. It compares that sample first against limit 1 and then against limit 2. Each comparison can give its own one-cycle interrupt pulse. The direction of each test (above or below) is set by a bit in that limit's word. Every instruction ends with a one-cycle done pulse.

Top module: `acq_sequencer`

## Requirements
- R1: A synchronous reset, asserted at any time, returns the block to idle: busy, track, conv_req, done, irq1 and irq2 are all 0.
- R2: The track output is high for exactly 9 + 2·D consecutive cycles when both instr[10] and instr[11] are 0. D is instr[15:12], an unsigned value from 0 to 15. The first of these cycles is the one that follows the clock edge at which start is sampled in idle.
- R3: When instr[10] (low-resolution mode) or instr[11] (watchdog mode) is 1, track is high for exactly 2 + 2·D cycles. During the conversion phase, conv_lo is 1 in these cases and 0 otherwise.
- R4: pos_chan equals instr[4:2] and neg_chan equals instr[7:5], both latched at start. neg_gnd is 1 exactly when instr[7:5] is 000, which selects ground. The values 001 to 111 select inputs 1 to 7.
- R5: conv_req rises in the cycle after the last track cycle. It stays high until conv_done is sampled high, and it is never high together with track.
- R6: When instr[11] is 0, done is high for the single cycle after the edge at which conv_done is accepted, and irq1 and irq2 stay 0.
- R7: In watchdog mode the sample is conv_res[12:4], read as a signed value. A limit word gives a magnitude in bits 7:0 and makes that magnitude negative when bit 8 is 1. Its bit 9 set to 1 raises the interrupt when the sample is strictly greater than the limit. Bit 9 set to 0 raises it when the sample is strictly less. Bits 15:10 of a limit word have no effect.
- R8: In watchdog mode, irq1 can pulse only in the cycle after conv_done is accepted. irq2 can pulse only in the next cycle. done pulses in the cycle after that.
- R9: A start pulse while busy is ignored. Changes on instr, lim1 and lim2 after the start cycle do not affect the running instruction.
- R10: done lasts one cycle, and busy is 0 in the cycle that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an instruction (accepted only when idle) |
| instr | input | 16 | Instruction word |
| lim1 | input | 16 | First limit word |
| lim2 | input | 16 | Second limit word |
| conv_done | input | 1 | Converter finished; conv_res valid |
| conv_res | input | 13 | Converter result, two's complement |
| busy | output | 1 | An instruction is in progress |
| track | output | 1 | Track/hold stage in tracking |
| conv_req | output | 1 | Conversion request |
| conv_lo | output | 1 | Converter should use the reduced resolution |
| pos_chan | output | 3 | Positive mux channel select |
| neg_chan | output | 3 | Negative mux channel select |
| neg_gnd | output | 1 | Negative input tied to ground |
| irq1 | output | 1 | Limit-1 interrupt pulse |
| irq2 | output | 1 | Limit-2 interrupt pulse |
| done | output | 1 | Instruction-complete pulse |

## Verification
Directed instructions cover the shortest and longest tracking windows in both length formulas, so the two base counts and the doubling of the delay field can be told apart. Watchdog cases use a sample equal to a limit, which separates strict from non-strict compares. They also use the most negative sample against a negative limit, which exposes any unsigned comparison or a wrong sign bit. Limit words with junk in their top bits test whether those bits are ignored. Random instructions, limits, results and converter delays are then mixed with start pulses and input changes during busy. These show whether a late start or a changed input corrupts the running instruction.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ACQ,
      ST_CONV,
      ST_CMP1,
      ST_CMP2,
      ST_DONE
   } seq_state_e;
endpackage

// File: rtl/acq_timer.sv
module acq_timer #(
   parameter int D_W     = 4,
   parameter int BASE_HI = 9,
   parameter int BASE_LO = 2
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           load,
   input  logic           lo_res,
   input  logic [D_W-1:0] dly,
   output logic           expired
);
   localparam int MAX_LEN = BASE_HI + 2 * ((1 << D_W) - 1);
   localparam int CNT_W   = $clog2(MAX_LEN);

   if (BASE_LO < 1 || BASE_HI < BASE_LO) begin : g_bad_base
      $error("acq_timer: base counts must satisfy 1 <= BASE_LO <= BASE_HI");
   end
   if (CNT_W < D_W + 1) begin : g_bad_width
      $error("acq_timer: counter too narrow for delay field");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] load_val;

   always_comb begin
      load_val = CNT_W'(lo_res ? BASE_LO - 1 : BASE_HI - 1) + CNT_W'({dly, 1'b0});
   end

   always_ff @(posedge clk) begin
      if (rst)                cnt <= '0;
      else if (load)          cnt <= load_val;
      else if (cnt != '0)     cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   p_count_down_r2: assert property (@(posedge clk) disable iff (rst)
      (!load && cnt != '0) |=> (cnt < $past(cnt)));
endmodule

// File: rtl/wd_compare.sv
module wd_compare #(
   parameter int SMP_W = 9,
   parameter int MAG_W = 8
) (
   input  logic signed [SMP_W-1:0] sample,
   input  logic [MAG_W+1:0]        lim_word,
   output logic                    hit
);
   localparam int CW = (SMP_W > MAG_W + 1) ? SMP_W + 1 : MAG_W + 2;

   logic signed [CW-1:0] s_ext;
   logic signed [CW-1:0] mag_ext;
   logic signed [CW-1:0] l_ext;

   always_comb begin
      s_ext   = CW'(sample);
      mag_ext = signed'(CW'(lim_word[MAG_W-1:0]));
      l_ext   = lim_word[MAG_W] ? -mag_ext : mag_ext;
      hit     = lim_word[MAG_W+1] ? (s_ext > l_ext) : (s_ext < l_ext);
   end
endmodule

// File: rtl/chan_decode.sv
module chan_decode #(
   parameter int SEL_W       = 3,
   parameter bit GND_ON_ZERO = 1'b1
) (
   input  logic [SEL_W-1:0] pos_code,
   input  logic [SEL_W-1:0] neg_code,
   output logic [SEL_W-1:0] pos_chan,
   output logic [SEL_W-1:0] neg_chan,
   output logic             neg_gnd
);
   assign pos_chan = pos_code;
   assign neg_chan = neg_code;

   if (GND_ON_ZERO) begin : g_gnd_zero
      assign neg_gnd = (neg_code == '0);
   end else begin : g_no_gnd
      assign neg_gnd = 1'b0;
   end
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
   import acq_seq_pkg::*;
#(
   parameter int INSTR_W   = 16,
   parameter int D_W       = 4,
   parameter int D_LSB     = 12,
   parameter int WD_BIT    = 11,
   parameter int LORES_BIT = 10,
   parameter int SEL_W     = 3,
   parameter int POS_LSB   = 2,
   parameter int NEG_LSB   = 5,
   parameter int BASE_HI   = 9,
   parameter int BASE_LO   = 2,
   parameter int RES_W     = 13,
   parameter int MAG_W     = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               start,
   input  logic [INSTR_W-1:0] instr,
   input  logic [INSTR_W-1:0] lim1,
   input  logic [INSTR_W-1:0] lim2,
   input  logic               conv_done,
   input  logic [RES_W-1:0]   conv_res,
   output logic               busy,
   output logic               track,
   output logic               conv_req,
   output logic               conv_lo,
   output logic [SEL_W-1:0]   pos_chan,
   output logic [SEL_W-1:0]   neg_chan,
   output logic               neg_gnd,
   output logic               irq1,
   output logic               irq2,
   output logic               done
);
   localparam int SMP_W = MAG_W + 1;
   localparam int LIM_W = MAG_W + 2;
   localparam int SHIFT = RES_W - SMP_W;

   if (D_LSB + D_W > INSTR_W || LIM_W > INSTR_W) begin : g_bad_fields
      $error("acq_sequencer: field does not fit in the word");
   end
   if (SHIFT < 0) begin : g_bad_res
      $error("acq_sequencer: result narrower than compare sample");
   end
   if (POS_LSB + SEL_W > INSTR_W || NEG_LSB + SEL_W > INSTR_W) begin : g_bad_sel
      $error("acq_sequencer: channel field outside the word");
   end

   seq_state_e               state, nxt;
   logic [SEL_W-1:0]         pos_q, neg_q;
   logic                     wd_q, lo_q;
   logic [LIM_W-1:0]         lim_q [2];
   logic signed [SMP_W-1:0]  smp_q;
   logic [1:0]               hit;
   logic                     t_expired;
   logic                     accept;
   logic                     unused_in;

   assign unused_in = ^{instr, lim1, lim2, conv_res};
   assign accept    = (state == ST_IDLE) && start;

   acq_timer #(.D_W(D_W), .BASE_HI(BASE_HI), .BASE_LO(BASE_LO)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .load    (accept),
      .lo_res  (instr[LORES_BIT] | instr[WD_BIT]),
      .dly     (instr[D_LSB +: D_W]),
      .expired (t_expired)
   );

   always_comb begin
      nxt = state;
      case (state)
         ST_IDLE: if (start)     nxt = ST_ACQ;
         ST_ACQ:  if (t_expired) nxt = ST_CONV;
         ST_CONV: if (conv_done) nxt = wd_q ? ST_CMP1 : ST_DONE;
         ST_CMP1:                nxt = ST_CMP2;
         ST_CMP2:                nxt = ST_DONE;
         ST_DONE:                nxt = ST_IDLE;
         default:                nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_IDLE;
         pos_q <= '0;
         neg_q <= '0;
         wd_q  <= 1'b0;
         lo_q  <= 1'b0;
         smp_q <= '0;
         for (int i = 0; i < 2; i++) lim_q[i] <= '0;
      end else begin
         state <= nxt;
         if (accept) begin
            pos_q    <= instr[POS_LSB +: SEL_W];
            neg_q    <= instr[NEG_LSB +: SEL_W];
            wd_q     <= instr[WD_BIT];
            lo_q     <= instr[LORES_BIT] | instr[WD_BIT];
            lim_q[0] <= lim1[LIM_W-1:0];
            lim_q[1] <= lim2[LIM_W-1:0];
         end
         if (state == ST_CONV && conv_done) smp_q <= conv_res[RES_W-1:SHIFT];
      end
   end

   for (genvar g = 0; g < 2; g++) begin : g_cmp
      wd_compare #(.SMP_W(SMP_W), .MAG_W(MAG_W)) u_cmp (
         .sample   (smp_q),
         .lim_word (lim_q[g]),
         .hit      (hit[g])
      );
   end

   chan_decode #(.SEL_W(SEL_W), .GND_ON_ZERO(1'b1)) u_chan (
      .pos_code (pos_q),
      .neg_code (neg_q),
      .pos_chan (pos_chan),
      .neg_chan (neg_chan),
      .neg_gnd  (neg_gnd)
   );

   assign busy     = (state != ST_IDLE);
   assign track    = (state == ST_ACQ);
   assign conv_req = (state == ST_CONV);
   assign conv_lo  = lo_q;
   assign done     = (state == ST_DONE);
   assign irq1     = (state == ST_CMP1) && hit[0];
   assign irq2     = (state == ST_CMP2) && hit[1];

   p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!busy && !irq1 && !irq2 && !done));
   p_track_start_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(track) |-> $past(start));
   p_req_excl_r5: assert property (@(posedge clk) disable iff (rst)
      !(track && conv_req));
   p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (conv_req && !conv_done) |=> conv_req);
   p_irq_wd_only_r7: assert property (@(posedge clk) disable iff (rst)
      (irq1 || irq2) |-> wd_q);
   p_cmp_order_r8: assert property (@(posedge clk) disable iff (rst)
      (state == ST_CMP2) |-> ($past(state) == ST_CMP1));
   p_latch_stable_r9: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy)) |-> ($stable(pos_q) && $stable(neg_q) && $stable(wd_q)));
   p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
      done |=> (!done && !busy));
endmodule

// File: tb/acq_sequencer_test.sv
`timescale 1ns/1ps
module acq_sequencer_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [15:0] instr = '0, lim1 = '0, lim2 = '0;
   logic        conv_done = 1'b0;
   logic [12:0] conv_res = '0;
   logic        busy, track, conv_req, conv_lo, neg_gnd, irq1, irq2, done;
   logic [2:0]  pos_chan, neg_chan;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   acq_sequencer uut (
      .clk(clk), .rst(rst), .start(start), .instr(instr), .lim1(lim1), .lim2(lim2),
      .conv_done(conv_done), .conv_res(conv_res), .busy(busy), .track(track),
      .conv_req(conv_req), .conv_lo(conv_lo), .pos_chan(pos_chan), .neg_chan(neg_chan),
      .neg_gnd(neg_gnd), .irq1(irq1), .irq2(irq2), .done(done)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_len(input logic [15:0] ins);
      int base = (ins[10] | ins[11]) ? 2 : 9;
      return base + 2 * int'(ins[15:12]);
   endfunction

   function automatic bit exp_hit(input logic [12:0] res, input logic [15:0] lw);
      int s = int'($signed(res));
      int l = int'(lw[7:0]);
      s = s >>> 4;
      if (lw[8]) l = -l;
      return lw[9] ? (s > l) : (s < l);
   endfunction

   task automatic run_one(input logic [15:0] ins, input logic [15:0] l1, input logic [15:0] l2,
                          input logic [12:0] res, input int waitc);
      int n = 0;
      bit e1, e2;
      e1 = exp_hit(res, l1);
      e2 = exp_hit(res, l2);
      @(negedge clk);
      instr = ins; lim1 = l1; lim2 = l2; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      instr = 16'($urandom); lim1 = 16'($urandom); lim2 = 16'($urandom);
      while (track && n < 100) begin
         n++;
         start = (n == 1);
         @(negedge clk);
      end
      start = 1'b0;
      if (ins[10] | ins[11]) chk(n == exp_len(ins), "R3", "track length low-res", n, exp_len(ins));
      else                   chk(n == exp_len(ins), "R2", "track length high-res", n, exp_len(ins));
      chk(conv_req == 1'b1, "R5", "conv_req after track", int'(conv_req), 1);
      chk(conv_lo == (ins[10] | ins[11]), "R3", "conv_lo", int'(conv_lo), int'(ins[10] | ins[11]));
      chk(pos_chan == ins[4:2], "R4", "pos_chan", int'(pos_chan), int'(ins[4:2]));
      chk(neg_chan == ins[7:5], "R4", "neg_chan", int'(neg_chan), int'(ins[7:5]));
      chk(neg_gnd == (ins[7:5] == 3'd0), "R4", "neg_gnd", int'(neg_gnd), int'(ins[7:5] == 3'd0));
      for (int k = 0; k < waitc; k++) begin
         @(negedge clk);
         chk(conv_req && !done, "R5", "conv_req held", int'(conv_req), 1);
      end
      conv_done = 1'b1; conv_res = res;
      @(negedge clk);
      conv_done = 1'b0; conv_res = 13'($urandom);
      chk(!conv_req, "R5", "conv_req released", int'(conv_req), 0);
      if (ins[11]) begin
         chk(irq1 == e1 && !done, "R7", "irq1 limit-1 compare", int'(irq1), int'(e1));
         @(negedge clk);
         chk(irq2 == e2 && !irq1, "R8", "irq2 after irq1", int'(irq2), int'(e2));
         @(negedge clk);
         chk(done && !irq2, "R8", "done after compares", int'(done), 1);
      end else begin
         chk(done && !irq1 && !irq2, "R6", "done without irq", int'(done), 1);
      end
      @(negedge clk);
      chk(!done && !busy, "R10", "single done then idle", int'(busy), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL R10 watchdog expired: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      int dummy;
      dummy = $urandom(32'd2024);
      repeat (3) @(negedge clk);
      chk(!busy && !track && !conv_req && !done && !irq1 && !irq2, "R1", "reset state", int'(busy), 0);
      rst = 1'b0;

      run_one(16'h0000, 16'h0000, 16'h0000, 13'd0, 0);
      run_one(16'hF0E4, 16'h0000, 16'h0000, 13'd100, 2);
      run_one(16'h0410, 16'h0000, 16'h0000, 13'd5, 1);
      run_one(16'hF400, 16'h0000, 16'h0000, 13'd5, 0);
      run_one(16'h38FC, 16'hFE0A, 16'h0305, 13'sd160, 1);
      run_one(16'h0800, 16'h01FF, 16'hFE00, -13'sd4096, 3);
      run_one(16'h0800, 16'h0000, 16'h0300, 13'sd4095, 0);

      // R1: reset in the middle of tracking
      @(negedge clk);
      instr = 16'hF000; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      chk(!busy && !track && !conv_req, "R1", "mid-run reset", int'(busy), 0);

      for (int i = 0; i < 40; i++) begin
         run_one(16'($urandom), 16'($urandom), 16'($urandom), 13'($urandom), int'($urandom_range(0, 3)));
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule